// File: doc/BRIEF.md
# Input Window Protection Sequencer

This block is the digital control core of a protection switch that sits between a supply input and a downstream system. It receives a sampled input-voltage code, a shutdown request and a slow timing tick, and it decides when the pass switch may conduct and when the system may be told that the input is healthy. The input is accepted only inside a voltage window bounded by an undervoltage and an overvoltage limit. Each limit has its own hysteresis band so that noise near a limit cannot make the switch chatter.

After the input settles inside the window, a start-up delay runs before the switch closes. A second delay then runs before the active-low fault flag is released. If the input leaves the window at any moment, the switch opens and the flag drops on the next clock, and both delays start again from zero. Shutdown only holds the switch open. It never hides a fault, and it never pauses the delays, so the flag always reports input health.

The sequencer has four states. `S_FAULT` is the reset state, in which the input is out of window or not yet qualified. `S_ARM` runs the start-up delay. `S_HOLD` has the switch closed and runs the flag delay. `S_GOOD` has the switch closed and the flag released. The transitions are FAULT→ARM on window entry, ARM→HOLD when the start-up delay expires, and HOLD→GOOD when the flag delay expires. Any state goes to FAULT when the input leaves the window. In every state the gate also requires shutdown to be low.

Top module: `ipw_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `gate_en` and `fault_n` are both 0 and the sequencer sits in `S_FAULT`.
- R2: From `S_FAULT`, the window is entered only when `vin_mv` lies in [UV_MV+UV_HYST_MV, OV_MV−OV_HYST_MV] (defaults 3300..6300). A code outside that range, such as 3280 or 6350, leaves the block in `S_FAULT`.
- R3: Once in the window, the input stays valid until `vin_mv` ≤ UV_MV or `vin_mv` ≥ OV_MV (defaults 3250 and 6400). Codes inside the hysteresis bands, such as 3260 or 6350, do not trip.
- R4: `gate_en` rises after the clock edge that samples the ON_TICKS-th `tick` pulse counted in `S_ARM`. Cycles without a tick do not advance the count.
- R5: `fault_n` rises after the clock edge that samples the FLAG_TICKS-th `tick` pulse counted in `S_HOLD`.
- R6: Leaving the window in any state drives `gate_en` and `fault_n` to 0 after the next clock edge, and both delays restart from zero.
- R7: `shutdown` high forces `gate_en` to 0 after the next edge. It has no effect on `fault_n` or on either delay count.
- R8: If `shutdown` is high when the start-up delay expires, the switch stays open and `fault_n` still rises after the flag delay. Releasing `shutdown` in `S_HOLD` or `S_GOOD` closes the switch after the next edge, with no new delay.
- R9: A window fault pulls `fault_n` low even while `shutdown` is high.
- R10: `tick` pulses sampled in `S_FAULT`, including on the edge that enters `S_ARM`, are not counted toward the start-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_mv | input | VW (16) | Sampled input voltage, unsigned millivolts |
| shutdown | input | 1 | Active-high request to hold the switch open |
| tick | input | 1 | One-cycle pulse from the slow delay oscillator |
| gate_en | output | 1 | Pass-switch gate enable, registered |
| fault_n | output | 1 | Active-low fault flag, registered, high means input healthy |

## Verification
A wrong state shows up at the ports on the clock after the faulty transition. A premature move into `S_HOLD` raises `gate_en` one or more ticks early. A missed move into `S_FAULT` leaves `gate_en` or `fault_n` high one cycle after an out-of-window code. A delay counter that leaks across states, or that counts ticks while in `S_FAULT`, shifts the gate edge by whole tick periods. The stimulus therefore places ticks on exact edges and checks every cycle, so that an off-by-one count is seen on the first edge where the outputs diverge.

// File: rtl/ipw_pkg.sv
package ipw_pkg;

    typedef enum logic [1:0] {
        S_FAULT = 2'd0,
        S_ARM   = 2'd1,
        S_HOLD  = 2'd2,
        S_GOOD  = 2'd3
    } ipw_state_e;

endpackage

// File: rtl/ipw_window.sv
// Hysteretic window qualifier: inner limits to enter, outer limits to leave.
module ipw_window #(
    parameter int VW         = 16,
    parameter int UV_MV      = 3250,
    parameter int UV_HYST_MV = 50,
    parameter int OV_MV      = 6400,
    parameter int OV_HYST_MV = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vin_mv,
    output logic          win_ok
);
    localparam logic [VW-1:0] ENTER_LO = VW'(UV_MV + UV_HYST_MV);
    localparam logic [VW-1:0] ENTER_HI = VW'(OV_MV - OV_HYST_MV);
    localparam logic [VW-1:0] LEAVE_LO = VW'(UV_MV);
    localparam logic [VW-1:0] LEAVE_HI = VW'(OV_MV);

    logic in_win_q;
    logic enter_ok;
    logic leave_hit;

    always_comb begin
        enter_ok  = (vin_mv >= ENTER_LO) && (vin_mv <= ENTER_HI);
        leave_hit = (vin_mv <= LEAVE_LO) || (vin_mv >= LEAVE_HI);
        win_ok    = in_win_q ? !leave_hit : enter_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_win_q <= 1'b0;
        else        in_win_q <= win_ok;
    end
endmodule

// File: rtl/ipw_delay.sv
// Tick-counting delay: expires on the TICKS-th tick seen while run is high.
module ipw_delay #(
    parameter int TICKS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (expire)  cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ipw_sequencer.sv
module ipw_sequencer #(
    parameter int VW         = 16,
    parameter int UV_MV      = 3250,
    parameter int UV_HYST_MV = 50,
    parameter int OV_MV      = 6400,
    parameter int OV_HYST_MV = 100,
    parameter int ON_TICKS   = 10000,
    parameter int FLAG_TICKS = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vin_mv,
    input  logic          shutdown,
    input  logic          tick,
    output logic          gate_en,
    output logic          fault_n
);
    import ipw_pkg::*;

    ipw_state_e state_q;
    ipw_state_e state_d;
    logic       win_ok;
    logic       arm_exp;
    logic       hold_exp;
    logic       gate_q;
    logic       flag_q;

    ipw_window #(
        .VW(VW), .UV_MV(UV_MV), .UV_HYST_MV(UV_HYST_MV),
        .OV_MV(OV_MV), .OV_HYST_MV(OV_HYST_MV)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .win_ok(win_ok)
    );

    ipw_delay #(.TICKS(ON_TICKS)) u_arm_delay (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_ARM),
        .tick(tick), .expire(arm_exp)
    );

    ipw_delay #(.TICKS(FLAG_TICKS)) u_hold_delay (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_HOLD),
        .tick(tick), .expire(hold_exp)
    );

    // Next-state logic: a window fault wins over every other transition.
    always_comb begin
        state_d = state_q;
        if (!win_ok) begin
            state_d = S_FAULT;
        end else begin
            unique case (state_q)
                S_FAULT: state_d = S_ARM;
                S_ARM:   if (arm_exp)  state_d = S_HOLD;
                S_HOLD:  if (hold_exp) state_d = S_GOOD;
                S_GOOD:  state_d = S_GOOD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FAULT;
        else        state_q <= state_d;
    end

    // Output register, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            gate_q <= ((state_d == S_HOLD) || (state_d == S_GOOD)) && !shutdown;
            flag_q <= (state_d == S_GOOD);
        end
    end

    assign gate_en = gate_q;
    assign fault_n = flag_q;
endmodule

// File: rtl/ipw_checker.sv
module ipw_checker #(
    parameter int VW    = 16,
    parameter int UV_MV = 3250,
    parameter int OV_MV = 6400
) (
    input logic                clk,
    input logic                rst_n,
    input logic [VW-1:0]       vin_mv,
    input logic                shutdown,
    input logic                gate_en,
    input logic                fault_n,
    input ipw_pkg::ipw_state_e state_q
);
    import ipw_pkg::*;

    localparam logic [VW-1:0] LO = VW'(UV_MV);
    localparam logic [VW-1:0] HI = VW'(OV_MV);

    // R1: outputs are low on the edge after reset is seen
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!gate_en && !fault_n));

    // R6 / R9: an out-of-window code clears both outputs on the next edge
    assert_trip_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((vin_mv <= LO) || (vin_mv >= HI)) |=> (!gate_en && !fault_n));

    // R7: a closed switch implies shutdown was low at the edge that set it
    assert_gate_respects_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> !$past(shutdown));

    // R5: the flag is released only out of the flag-delay state
    assert_flag_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> ($past(state_q) == S_HOLD));

    // R4: the gate never closes straight from the fault state
    assert_gate_not_from_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(state_q) != S_FAULT));
endmodule

bind ipw_sequencer ipw_checker #(
    .VW(VW), .UV_MV(UV_MV), .OV_MV(OV_MV)
) u_ipw_checker (
    .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .shutdown(shutdown),
    .gate_en(gate_en), .fault_n(fault_n), .state_q(state_q)
);

// File: tb/tb_ipw_sequencer.sv
module tb_ipw_sequencer;
    localparam int ON_T = 3;
    localparam int FL_T = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vin_mv = 16'd0;
    logic        shutdown = 1'b0;
    logic        tick = 1'b0;
    logic        gate_en;
    logic        fault_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ipw_sequencer #(.ON_TICKS(ON_T), .FLAG_TICKS(FL_T)) dut (
        .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .shutdown(shutdown),
        .tick(tick), .gate_en(gate_en), .fault_n(fault_n)
    );

    typedef struct packed {
        logic [15:0] vin;
        logic        sd;
        logic        tk;
        logic        g;
        logic        f;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t TBL [NV] = '{
        '{16'd5000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // 0  enter window: R2
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // 1  R4 tick 1
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // 2  R4 tick 2
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // 3  R4 gate closes
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // 4  R5 flag tick 1
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // 5  R5 flag released
        '{16'd3260, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // 6  R3 low band, no trip
        '{16'd6350, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // 7  R3 high band, no trip
        '{16'd6400, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // 8  R6 trip at upper limit
        '{16'd6350, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // 9  R2 band not entered
        '{16'd3280, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // 10 R2 band not entered
        '{16'd3300, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // 11 R10 entry-edge tick ignored
        '{16'd3300, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // 12 R10 first counted tick
        '{16'd7000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // 13 R6 spike during start delay
        '{16'd5000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // 14 R6 re-enter
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // 15 R6 count restarted
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // 16
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},  // 17 R6 full delay again
        '{16'd6500, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // 18 R6 spike during flag delay
        '{16'd5000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // 19 R8 shutdown through delays
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // 20
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // 21
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // 22 R8 expiry, switch held open
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // 23
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8},  // 24 R8 flag rises in shutdown
        '{16'd5000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // 25 R8 release closes at once
        '{16'd5000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // 26 R7 opens, flag kept
        '{16'd3000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // 27 R9 fault seen in shutdown
        '{16'd3000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // 28 R10 tick in fault ignored
        '{16'd5000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // 29 R7 enter
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // 30 R7 shutdown does not pause
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // 31
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // 32 R7 delay unchanged
        '{16'd5000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // 33 R4 no tick, holds
        '{16'd3250, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // 34 R3 trip at lower limit
        '{16'd5000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // 35 R2 enter
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // 36
        '{16'd5000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // 37
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // 38
        '{16'd5000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // 39 R7 shutdown in flag delay
        '{16'd5000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5}   // 40 R5 flag count kept running
    };

    task automatic check(input string tag, input logic eg, input logic ef);
        n_cmp++;
        if (gate_en !== eg || fault_n !== ef) begin
            n_bad++;
            $display("FAIL %s: gate_en/fault_n = %b/%b, expected %b/%b",
                     tag, gate_en, fault_n, eg, ef);
        end
    endtask

    task automatic step(input logic [15:0] v, input logic s, input logic t);
        vin_mv = v; shutdown = s; tick = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, both during and after reset
        vin_mv = 16'd5000;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0);
        vin_mv = 16'd0;
        rst_n = 1'b1;
        step(16'd0, 1'b0, 1'b1);
        check("R1 after release", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].vin, TBL[i].sd, TBL[i].tk);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].g, TBL[i].f);
        end

        // R1: asynchronous reset from the healthy state
        #1 rst_n = 1'b0;
        #0.5 check("R1 async reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: sparse ticks, gate closes only on the third counted tick
        step(16'd4200, 1'b0, 1'b0);
        check("R4 sparse enter", 1'b0, 1'b0);
        for (int k = 0; k < ON_T; k++) begin
            for (int j = 0; j < 4; j++) begin
                step(16'd4200, 1'b0, 1'b0);
                check("R4 idle cycle", (k == ON_T) ? 1'b1 : 1'b0, 1'b0);
            end
            step(16'd4200, 1'b0, 1'b1);
            check("R4 sparse tick", (k == ON_T - 1) ? 1'b1 : 1'b0, 1'b0);
        end

        // R3: window edges exactly at the entry limits
        step(16'd6300, 1'b0, 1'b0);
        check("R3 upper entry edge held", 1'b1, 1'b0);
        step(16'd6399, 1'b0, 1'b0);
        check("R3 just below upper limit", 1'b1, 1'b0);
        step(16'd6400, 1'b0, 1'b0);
        check("R6 upper trip", 1'b0, 1'b0);
        step(16'd6300, 1'b0, 1'b0);
        check("R2 upper entry edge accepted", 1'b0, 1'b0);
        step(16'd6300, 1'b0, 1'b1);
        step(16'd6300, 1'b0, 1'b1);
        step(16'd6300, 1'b0, 1'b1);
        check("R2 entry at 6300 counts", 1'b1, 1'b0);

        finish_run();
    end
endmodule